// File: doc/BRIEF.md
# Selectable-Width Frame Check Sequence Unit

This block computes and checks the frame check sequence of an HDLC-like framed link. An external framer delivers a byte stream and marks the first byte of each frame, the last byte, each valid byte, and each byte that must stay out of the check: opening and closing flags and inserted transparency bytes. The framer also chooses, for each frame, between a 16-bit and a 32-bit check and between transmit and receive handling. The unit samples both choices with the frame's first byte and holds them until the frame ends.

In transmit mode, the unit runs the check over the covered bytes. After the last byte it emits the complemented check value, low-order byte first, on a separate byte output. The framer holds off new input while emission is in progress. In receive mode, the framer passes the received check bytes as covered bytes. One cycle after the last byte, the unit raises a done pulse together with a good/bad verdict. A bad verdict tells the framer to discard the frame; the unit requests no retransmission.

The controller has three states. ST_IDLE waits for a frame-start byte. ST_FRAME absorbs frame bytes. ST_EMIT drives the check bytes. The transitions are: IDLE to FRAME when a start byte arrives without an end marker. FRAME to FRAME on any other byte. IDLE or FRAME to EMIT when an end byte is accepted in transmit mode. IDLE or FRAME to IDLE when an end byte is accepted in receive mode. EMIT to IDLE after the last check byte.

Top module: `fcs_unit`

## Requirements
- R1: In 16-bit mode, bits enter least significant bit first through the reflected generator 0x8408 (x^16+x^12+x^5+1), the register starts at 0xFFFF, and the transmitted check is the complement. For the ASCII bytes "123456789", the emitted bytes are 0x6E then 0x90.
- R2: In 32-bit mode, the reflected generator is 0xEDB88320 (normal form 0x04C11DB7), the preset is 0xFFFFFFFF, and the result is complemented. For "123456789", the emitted bytes are 0x26, 0x39, 0xF4, 0xCB.
- R3: `wide_sel` and `tx_mode` are taken only on the accepted frame-start byte. Changes to them later in the frame have no effect on that frame's check.
- R4: A valid byte with `in_skip`=1 leaves the check register unchanged, including when it carries the start or end marker.
- R5: In transmit mode, `out_valid` is high for exactly 2 (16-bit) or 4 (32-bit) consecutive cycles. These begin the cycle after the end byte is accepted, and `out_data` carries the complemented check value low-order byte first.
- R6: In receive mode, `chk_done` pulses for one cycle, the cycle after the end byte is accepted. `chk_good` is 1 only if the register, run over the data and the received check bytes, equals 0xF0B8 (16-bit) or 0xDEBB20E3 (32-bit).
- R7: Bytes presented in ST_EMIT are ignored, and valid bytes without the start marker in ST_IDLE are ignored.
- R8: A single byte that carries both the start and end markers forms a complete one-byte frame.
- R9: Frames of 4096 covered octets give correct results. The unit has no length limit.
- R10: After reset, `out_valid`, `chk_done` and `chk_good` are 0 and the unit is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is present on in_data |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_skip | input | 1 | Byte is excluded from the check (flag or transparency byte) |
| in_data | input | 8 | Frame byte |
| tx_mode | input | 1 | 1 = transmit (emit check), 0 = receive (verify check); sampled at frame start |
| wide_sel | input | 1 | 1 = 32-bit check, 0 = 16-bit check; sampled at frame start |
| out_valid | output | 1 | A check byte is present on out_data |
| out_data | output | 8 | Emitted check byte, low-order first; 0 when out_valid is low |
| chk_done | output | 1 | One-cycle pulse giving a receive verdict |
| chk_good | output | 1 | Verdict: 1 = residue matched, 0 = discard frame |

## Verification
On every cycle, the assertions check the following: a verdict pulse always follows an accepted end byte; a check byte never appears together with a verdict; emission never starts without a preceding end byte; the latched width stays fixed inside a frame; and excluded mid-frame bytes leave the register untouched. Only the bench's scenarios can show that the emitted and verified values match the generators, presets and complement. The same holds for the residue verdict on clean and corrupted frames, for the byte order, and for the handling of stray bytes while idle or emitting.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_EMIT  = 2'd2
    } fcs_state_t;

    localparam int          NARROW_W     = 16;
    localparam int          WIDE_W       = 32;
    localparam logic [15:0] NARROW_POLY  = 16'h8408;
    localparam logic [31:0] WIDE_POLY    = 32'hEDB88320;
    localparam logic [15:0] NARROW_RESID = 16'hF0B8;
    localparam logic [31:0] WIDE_RESID   = 32'hDEBB20E3;
endpackage

// File: rtl/fcs_crc_step.sv
module fcs_crc_step #(
    parameter int            W    = 16,
    parameter logic [W-1:0]  POLY = '0,
    parameter int            BITS = 8
) (
    input  logic [W-1:0]    crc_in,
    input  logic [BITS-1:0] byte_in,
    output logic [W-1:0]    crc_out
);
    always_comb begin
        logic [W-1:0] c;
        c = crc_in;
        for (int i = 0; i < BITS; i++) begin
            if (c[0] ^ byte_in[i]) c = (c >> 1) ^ POLY;
            else                   c = c >> 1;
        end
        crc_out = c;
    end
endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              start,
    input  logic              take,
    input  logic              wide_eff,
    input  logic [7:0]        data,
    output logic [WIDE_W-1:0] crc_q,
    output logic [WIDE_W-1:0] crc_next
);
    logic [WIDE_W-1:0]   base;
    logic [NARROW_W-1:0] s16;
    logic [WIDE_W-1:0]   s32;

    always_comb begin
        if (start) base = wide_eff ? '1 : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        else       base = crc_q;
    end

    fcs_crc_step #(.W(NARROW_W), .POLY(NARROW_POLY)) u_step16 (
        .crc_in(base[NARROW_W-1:0]), .byte_in(data), .crc_out(s16));
    fcs_crc_step #(.W(WIDE_W), .POLY(WIDE_POLY)) u_step32 (
        .crc_in(base), .byte_in(data), .crc_out(s32));

    always_comb begin
        if (!take)         crc_next = base;
        else if (wide_eff) crc_next = s32;
        else               crc_next = {{(WIDE_W-NARROW_W){1'b0}}, s16};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= '0;
        else if (load) crc_q <= crc_next;
    end

    // R4
    skip_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !take && !start) |=> $stable(crc_q));
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              tx_mode,
    input  logic              wide_sel,
    input  logic [WIDE_W-1:0] crc_next,
    output logic              accept,
    output logic              start,
    output logic              wide_eff,
    output logic [1:0]        emit_idx,
    output logic              out_valid,
    output logic              chk_done,
    output logic              chk_good
);
    fcs_state_t state_q, state_d;
    logic       wide_q, tx_q, tx_eff, fin, last_emit, match;
    logic [1:0] idx_q;

    assign accept    = in_valid && (state_q != ST_EMIT) && (state_q == ST_FRAME || in_sof);
    assign start     = accept && in_sof;
    assign fin       = accept && in_eof;
    assign wide_eff  = start ? wide_sel : wide_q;
    assign tx_eff    = start ? tx_mode  : tx_q;
    assign last_emit = wide_q ? (idx_q == 2'd3) : (idx_q == 2'd1);
    assign match     = wide_eff ? (crc_next == WIDE_RESID)
                                : (crc_next[NARROW_W-1:0] == NARROW_RESID);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FRAME: begin
                if (fin)         state_d = tx_eff ? ST_EMIT : ST_IDLE;
                else if (accept) state_d = ST_FRAME;
            end
            ST_EMIT: if (last_emit) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q   <= 1'b0;
            tx_q     <= 1'b0;
            idx_q    <= '0;
            chk_done <= 1'b0;
            chk_good <= 1'b0;
        end else begin
            if (start) begin
                wide_q <= wide_sel;
                tx_q   <= tx_mode;
            end
            idx_q    <= (state_q == ST_EMIT) ? idx_q + 2'd1 : 2'd0;
            chk_done <= fin && !tx_eff;
            if (fin && !tx_eff) chk_good <= match;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign emit_idx  = idx_q;

    // R6
    done_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(in_valid && in_eof));
    // R5
    emit_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_eof));
    // R5
    no_emit_and_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && chk_done));
    // R3
    width_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME && !(in_valid && in_sof)) |=> $stable(wide_q));
    // R5
    narrow_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide_q) |-> (idx_q < 2'd2));
endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
    import fcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic       in_skip,
    input  logic [7:0] in_data,
    input  logic       tx_mode,
    input  logic       wide_sel,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       chk_done,
    output logic       chk_good
);
    logic              accept, start, wide_eff;
    logic [1:0]        emit_idx;
    logic [WIDE_W-1:0] crc_q, crc_next, fcs_val;

    fcs_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .tx_mode(tx_mode), .wide_sel(wide_sel),
        .crc_next(crc_next), .accept(accept), .start(start),
        .wide_eff(wide_eff), .emit_idx(emit_idx), .out_valid(out_valid),
        .chk_done(chk_done), .chk_good(chk_good));

    fcs_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .load(accept), .start(start),
        .take(accept && !in_skip), .wide_eff(wide_eff), .data(in_data),
        .crc_q(crc_q), .crc_next(crc_next));

    assign fcs_val  = ~crc_q;
    assign out_data = out_valid ? fcs_val[8*emit_idx +: 8] : 8'h00;
endmodule

// File: tb/sim_fcs_unit.sv
module sim_fcs_unit;
    localparam int CLK_P = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sof = 0, in_eof = 0, in_skip = 0, tx_mode = 0, wide_sel = 0;
    logic [7:0] in_data = 0;
    logic out_valid, chk_done, chk_good;
    logic [7:0] out_data;

    int errors = 0, checks = 0;
    logic [7:0] pay [0:4095];
    logic [31:0] got_fcs;

    always #(CLK_P/2) clk = ~clk;

    fcs_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_skip(in_skip), .in_data(in_data), .tx_mode(tx_mode),
        .wide_sel(wide_sel), .out_valid(out_valid), .out_data(out_data),
        .chk_done(chk_done), .chk_good(chk_good));

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] d, input logic w);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ (w ? 32'hEDB88320 : 32'h00008408);
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] d, input logic s, input logic e, input logic k, input logic w, input logic t);
        in_valid = 1; in_data = d; in_sof = s; in_eof = e; in_skip = k;
        wide_sel = w; tx_mode = t;
        @(negedge clk);
    endtask

    task automatic idle_in();
        in_valid = 0; in_sof = 0; in_eof = 0; in_skip = 0; in_data = 0;
    endtask

    // Sends a frame built from pay[0:n-1]; flags/escapes are inserted as skipped bytes.
    task automatic run_frame(input int n, input logic w, input logic t, input logic corrupt,
                             input logic stray, input logic toggle, input logic flags);
        logic [31:0] c, fcs, mask;
        int nf;
        mask = w ? 32'hFFFFFFFF : 32'h0000FFFF;
        nf = w ? 4 : 2;
        c = mask;
        for (int i = 0; i < n; i++) c = ref_step(c, pay[i], w);
        fcs = ~c & mask;
        if (corrupt) pay[n/2] = pay[n/2] ^ 8'h10;
        if (stray) for (int i = 0; i < 3; i++) put(8'h55, 0, 0, 0, ~w, ~t); // R7 idle stray
        if (flags) put(8'h7E, 1, 0, 1, w, t);
        for (int i = 0; i < n; i++) begin
            logic s, e, tw;
            s = (i == 0) && !flags;
            e = (i == n-1) && t && !(flags && 0);
            tw = (toggle && !s) ? logic'($urandom_range(0, 1)) : w;
            if (!s && $urandom_range(0, 4) == 0) put(8'h7D, 0, 0, 1, tw, ~t); // R4 skipped byte
            put(pay[i], s, e, 0, tw, (toggle && !s) ? ~t : t);
        end
        if (t) begin
            idle_in();
            got_fcs = 0;
            for (int b = 0; b < nf; b++) begin
                check("R5 out_valid", out_valid, 1);
                got_fcs[8*b +: 8] = out_data;
                if (stray && b < nf-1) put(8'hA5, 1, 1, 0, ~w, 0); // R7 ignored during emit
                else @(negedge clk);
                idle_in();
            end
            check(w ? "R2 fcs" : "R1 fcs", got_fcs, fcs);
            check("R5 emit end", out_valid, 0);
        end else begin
            for (int b = 0; b < nf; b++)
                put(fcs[8*b +: 8], 0, (b == nf-1) && !flags, 0, toggle ? ~w : w, toggle ? 1'b1 : 1'b0);
            if (flags) put(8'h7E, 0, 1, 1, w, 0); // R4 closing flag with eof
            idle_in();
            check("R6 chk_done", chk_done, 1);
            check("R6 chk_good", chk_good, !corrupt);
            @(negedge clk);
            check("R6 pulse", chk_done, 0);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", out_valid, 0);
        check("R10 chk_done", chk_done, 0);
        check("R10 chk_good", chk_good, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 / R2 directed known values
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + i[7:0];
        run_frame(9, 0, 1, 0, 0, 0, 0);
        check("R1 known", got_fcs, 32'h0000906E);
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + i[7:0];
        run_frame(9, 1, 1, 0, 0, 0, 1);
        check("R2 known", got_fcs, 32'hCBF43926);
        // R8 single-byte frames
        pay[0] = 8'h3C; run_frame(1, 0, 1, 0, 0, 0, 0);
        pay[0] = 8'hC3; run_frame(1, 1, 1, 0, 0, 0, 0);
        // R9 4096-octet frames
        for (int i = 0; i < 4096; i++) pay[i] = 8'($urandom);
        run_frame(4096, 1, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4096; i++) pay[i] = 8'($urandom);
        run_frame(4096, 0, 1, 0, 0, 0, 0);
        // random mix: R3 toggles, R4 skips, R6 corruption, R7 strays
        for (int f = 0; f < 60; f++) begin
            int n;
            logic w, t;
            n = $urandom_range(2, 64);
            w = 1'($urandom_range(0, 1));
            t = 1'($urandom_range(0, 1));
            for (int i = 0; i < n; i++) pay[i] = 8'($urandom);
            run_frame(n, w, t, (!t) && ($urandom_range(0, 2) == 0),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 1)));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule